// File: doc/BRIEF.md
# Integer Adder with Split-Width Carry and Overflow Status

This unit performs the add and add-with-carry operations of a 64-bit integer datapath. A single full-width addition yields the sum and, from the same carry chain, a carry-out and a signed-overflow indication at two widths: the whole word and its low 32-bit half. The unit holds these indications in a small status register, together with a sticky summary-overflow bit. Per-operation controls choose which status fields each operation may rewrite.

Each accepted operation (`issue_i` high at a rising clock edge) registers its sum and its status updates. Both become visible in the following cycle. An extended add takes its carry-in from the stored full-width carry as it stood before the operation. Back-to-back extended adds therefore chain naturally. When the record bit is set, the unit also registers a 4-bit comparison field that describes the signed result and the updated summary-overflow bit.

Top module: `addflag_unit`

## Requirements
- R1: One cycle after an accepted operation, `sum_o` equals (A + B + carry-in) modulo 2^64. While no operation is accepted, `sum_o` keeps its value.
- R2: `ca_o` becomes the carry out of bit 63, and `ca32_o` becomes the carry out of bit 31, of that same addition including carry-in.
- R3: `ov_o` becomes 1 exactly when A and B, read as signed 64-bit numbers, share a sign and the 64-bit result has the other sign. The carry-in is included (for example 0x7FFF_FFFF_FFFF_FFFF + 0 + carry-in 1 overflows).
- R4: `ov32_o` applies the rule of R3 to bits 31:0 of A, B and the result (for example 0x7FFF_FFFF + 1 sets it while `ov_o` stays 0).
- R5: When `ext_i` = 1, the carry-in is the stored `ca_o` value from before the operation. When `ext_i` = 0, the carry-in is 0.
- R6: An extended operation always rewrites `ca_o` and `ca32_o`. A plain operation rewrites them only when `ca_wr_i` = 1, and otherwise leaves them unchanged.
- R7: `ov_o` and `ov32_o` are rewritten only by operations with `ov_en_i` = 1. Any other operation leaves both unchanged.
- R8: `so_o` is set to 1 by any operation that writes `ov_o` as 1. No operation ever clears it; only reset does.
- R9: A recorded operation (`rec_i` = 1) sets `cr_o` to {LT, GT, EQ, SO}, with LT in bit 3 and SO in bit 0. LT, GT and EQ compare the signed 64-bit result with zero, and SO is the updated `so_o`. `cr_valid_o` is high for exactly the cycle after a recorded operation. Non-recorded operations leave `cr_o` unchanged.
- R10: A cycle with `issue_i` = 0 changes no output except `cr_valid_o`, which becomes 0.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| issue_i | input | 1 | Accept an operation this cycle |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand |
| ext_i | input | 1 | Extended add: carry-in from stored carry |
| ca_wr_i | input | 1 | Plain add may update the carry fields |
| ov_en_i | input | 1 | Operation may update the overflow fields |
| rec_i | input | 1 | Record form: produce the comparison field |
| sum_o | output | 64 | Registered result |
| ca_o | output | 1 | Stored carry out of bit 63 |
| ca32_o | output | 1 | Stored carry out of bit 31 |
| ov_o | output | 1 | Stored 64-bit signed overflow |
| ov32_o | output | 1 | Stored 32-bit signed overflow |
| so_o | output | 1 | Sticky summary overflow |
| cr_o | output | 4 | Comparison field {LT, GT, EQ, SO} |
| cr_valid_o | output | 1 | Pulses one cycle after a recorded operation |

## Verification
The interesting collision is an extended add whose carry-in comes from the stored carry while the same operation rewrites that carry and raises overflow. The carry and overflow updates and the sticky summary bit all land at one edge, and the comparison field must pick up the new summary bit rather than the old one. The bench provokes this by issuing extended operations back to back over a grid of operands placed around bit 31 and bit 63, and then over random operands with mixed enables. After every edge it compares each status output against a bench model built on signed range checks and separate low-half sums.

// File: rtl/addflag_pkg.sv
package addflag_pkg;
  typedef struct packed {
    logic carry;
    logic carry_lo;
    logic ovf;
    logic ovf_lo;
    logic sticky;
  } flags_t;

  localparam int unsigned CR_W = 4;
endpackage

// File: rtl/addflag_sum.sv
module addflag_sum #(
  parameter int unsigned W = 64,
  parameter int unsigned H = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         carry_lo_o,
  output logic         ovf_o,
  output logic         ovf_lo_o
);
  localparam int unsigned TOP = W - 1;
  localparam int unsigned LTOP = H - 1;

  logic [W:0] full;
  logic       cin_top;
  logic       cin_ltop;

  always_comb begin
    full       = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_o      = full[W-1:0];
    carry_o    = full[W];
    // carry into bit H equals carry out of bit H-1
    carry_lo_o = a_i[H] ^ b_i[H] ^ full[H];
    cin_top    = a_i[TOP] ^ b_i[TOP] ^ full[TOP];
    cin_ltop   = a_i[LTOP] ^ b_i[LTOP] ^ full[LTOP];
    // signed overflow: carry into top bit differs from carry out of it
    ovf_o      = cin_top ^ carry_o;
    ovf_lo_o   = cin_ltop ^ carry_lo_o;
  end
endmodule

// File: rtl/addflag_status.sv
module addflag_status
  import addflag_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_carry_i,
  input  logic   wr_ovf_i,
  input  flags_t new_i,
  output flags_t flags_q_o,
  output logic   sticky_next_o
);
  flags_t flags_d;
  flags_t flags_q;
  logic   upd;

  always_comb begin
    flags_d = flags_q;
    if (wr_carry_i) begin
      flags_d.carry    = new_i.carry;
      flags_d.carry_lo = new_i.carry_lo;
    end
    if (wr_ovf_i) begin
      flags_d.ovf    = new_i.ovf;
      flags_d.ovf_lo = new_i.ovf_lo;
      flags_d.sticky = flags_q.sticky | new_i.ovf;
    end
    upd = wr_carry_i | wr_ovf_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (upd) begin
      flags_q <= flags_d;
    end
  end

  assign flags_q_o     = flags_q;
  assign sticky_next_o = flags_d.sticky;
endmodule

// File: rtl/addflag_cond.sv
module addflag_cond
  import addflag_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]    res_i,
  input  logic            so_i,
  output logic [CR_W-1:0] cr_o
);
  logic neg;
  logic zero;

  always_comb begin
    neg  = res_i[W-1];
    zero = (res_i == '0);
    cr_o = {neg, ~neg & ~zero, zero, so_i};
  end
endmodule

// File: rtl/addflag_unit.sv
module addflag_unit
  import addflag_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned LOW  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic [XLEN-1:0] op_a_i,
  input  logic [XLEN-1:0] op_b_i,
  input  logic            ext_i,
  input  logic            ca_wr_i,
  input  logic            ov_en_i,
  input  logic            rec_i,
  output logic [XLEN-1:0] sum_o,
  output logic            ca_o,
  output logic            ca32_o,
  output logic            ov_o,
  output logic            ov32_o,
  output logic            so_o,
  output logic [3:0]      cr_o,
  output logic            cr_valid_o
);
  flags_t            flags_q;
  flags_t            flags_new;
  logic              cin;
  logic [XLEN-1:0]   sum_d;
  logic [XLEN-1:0]   sum_q;
  logic              sticky_next;
  logic [CR_W-1:0]   cr_d;
  logic [CR_W-1:0]   cr_q;
  logic              cr_vld_q;
  logic              wr_carry;
  logic              wr_ovf;
  logic              cr_en;

  assign cin = ext_i & flags_q.carry;

  addflag_sum #(.W(XLEN), .H(LOW)) u_sum (
    .a_i        (op_a_i),
    .b_i        (op_b_i),
    .cin_i      (cin),
    .sum_o      (sum_d),
    .carry_o    (flags_new.carry),
    .carry_lo_o (flags_new.carry_lo),
    .ovf_o      (flags_new.ovf),
    .ovf_lo_o   (flags_new.ovf_lo)
  );
  assign flags_new.sticky = 1'b0;

  always_comb begin
    wr_carry = issue_i & (ext_i | ca_wr_i);
    wr_ovf   = issue_i & ov_en_i;
    cr_en    = issue_i & rec_i;
  end

  addflag_status u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_carry_i    (wr_carry),
    .wr_ovf_i      (wr_ovf),
    .new_i         (flags_new),
    .flags_q_o     (flags_q),
    .sticky_next_o (sticky_next)
  );

  addflag_cond #(.W(XLEN)) u_cond (
    .res_i (sum_d),
    .so_i  (sticky_next),
    .cr_o  (cr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (issue_i) begin
      sum_q <= sum_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q <= '0;
    end else if (cr_en) begin
      cr_q <= cr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_vld_q <= 1'b0;
    end else begin
      cr_vld_q <= cr_en;
    end
  end

  assign sum_o      = sum_q;
  assign ca_o       = flags_q.carry;
  assign ca32_o     = flags_q.carry_lo;
  assign ov_o       = flags_q.ovf;
  assign ov32_o     = flags_q.ovf_lo;
  assign so_o       = flags_q.sticky;
  assign cr_o       = cr_q;
  assign cr_valid_o = cr_vld_q;
endmodule

// File: rtl/addflag_chk.sv
module addflag_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned LOW  = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_i,
  input logic [XLEN-1:0] op_a_i,
  input logic [XLEN-1:0] op_b_i,
  input logic            ext_i,
  input logic            ca_wr_i,
  input logic            ov_en_i,
  input logic            rec_i,
  input logic [XLEN-1:0] sum_o,
  input logic            ca_o,
  input logic            ca32_o,
  input logic            ov_o,
  input logic            ov32_o,
  input logic            so_o,
  input logic [3:0]      cr_o,
  input logic            cr_valid_o
);
  // R3: operands of opposite sign never overflow, whatever the carry-in
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && ov_en_i && (op_a_i[XLEN-1] != op_b_i[XLEN-1]) |=> !ov_o);

  // R4: same rule on the low half
  assert_no_overflow32_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && ov_en_i && (op_a_i[LOW-1] != op_b_i[LOW-1]) |=> !ov32_o);

  // R6: plain add without carry write keeps carry fields
  assert_carry_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && !ext_i && !ca_wr_i |=> $stable(ca_o) && $stable(ca32_o));

  // R7: overflow fields change only under the enable
  assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_i && ov_en_i) |=> $stable(ov_o) && $stable(ov32_o));

  // R8: summary overflow never falls
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    so_o |=> so_o);

  // R8: an enabled overflow leaves the summary set
  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && ov_en_i |=> (so_o == ($past(so_o) | ov_o)));

  // R9: exactly one of LT/GT/EQ, SO bit matches the summary flag
  assert_cr_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid_o |-> ($countones(cr_o[3:1]) == 1) && (cr_o[0] == so_o));

  // R9: the pulse follows a recorded issue
  assert_cr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && rec_i |=> cr_valid_o);

  // R10: idle cycle changes nothing
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> $stable(sum_o) && $stable(ca_o) && $stable(ov_o)
                 && $stable(so_o) && $stable(cr_o) && !cr_valid_o);
endmodule

bind addflag_unit addflag_chk #(.XLEN(XLEN), .LOW(LOW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_i    (issue_i),
  .op_a_i     (op_a_i),
  .op_b_i     (op_b_i),
  .ext_i      (ext_i),
  .ca_wr_i    (ca_wr_i),
  .ov_en_i    (ov_en_i),
  .rec_i      (rec_i),
  .sum_o      (sum_o),
  .ca_o       (ca_o),
  .ca32_o     (ca32_o),
  .ov_o       (ov_o),
  .ov32_o     (ov32_o),
  .so_o       (so_o),
  .cr_o       (cr_o),
  .cr_valid_o (cr_valid_o)
);

// File: tb/sim_addflag_unit.sv
module sim_addflag_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        ext = 1'b0;
  logic        cw = 1'b0;
  logic        oe = 1'b0;
  logic        rc = 1'b0;
  logic [63:0] sum;
  logic        ca, ca32, ov, ov32, so, crv;
  logic [3:0]  cr;

  int n_chk = 0;
  int n_bad = 0;

  // bench model of stored state
  logic [63:0] m_sum = '0;
  logic        m_ca = 0, m_ca32 = 0, m_ov = 0, m_ov32 = 0, m_so = 0, m_crv = 0;
  logic [3:0]  m_cr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addflag_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .op_a_i(a), .op_b_i(b),
    .ext_i(ext), .ca_wr_i(cw), .ov_en_i(oe), .rec_i(rc),
    .sum_o(sum), .ca_o(ca), .ca32_o(ca32), .ov_o(ov), .ov32_o(ov32),
    .so_o(so), .cr_o(cr), .cr_valid_o(crv)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R1 sum", sum, m_sum);
    chk("R2 carry64", {63'd0, ca}, {63'd0, m_ca});
    chk("R2 carry32", {63'd0, ca32}, {63'd0, m_ca32});
    chk("R3 ovf64", {63'd0, ov}, {63'd0, m_ov});
    chk("R4 ovf32", {63'd0, ov32}, {63'd0, m_ov32});
    chk("R8 sticky", {63'd0, so}, {63'd0, m_so});
    chk("R9 cr", {59'd0, crv, cr}, {59'd0, m_crv, m_cr});
  endtask

  // drive at a negedge, advance model, check at next negedge
  task automatic op(input logic v, input logic [63:0] xa, input logic [63:0] xb,
                    input logic xe, input logic xc, input logic xo, input logic xr);
    logic [64:0] full;
    logic [32:0] lo;
    logic signed [65:0] s64;
    longint s32;
    logic cin, e_ov, e_ov32;
    issue = v; a = xa; b = xb; ext = xe; cw = xc; oe = xo; rc = xr;
    m_crv = 1'b0;
    if (v) begin
      cin   = xe ? m_ca : 1'b0;  // R5 carry-in source
      full  = {1'b0, xa} + {1'b0, xb} + {64'd0, cin};
      lo    = {1'b0, xa[31:0]} + {1'b0, xb[31:0]} + {32'd0, cin};
      s64   = $signed({{2{xa[63]}}, xa}) + $signed({{2{xb[63]}}, xb}) + $signed({65'd0, cin});
      s32   = longint'($signed(xa[31:0])) + longint'($signed(xb[31:0])) + longint'(cin);
      e_ov  = (s64 > ((66'sd1 <<< 63) - 66'sd1)) || (s64 < -(66'sd1 <<< 63));
      e_ov32 = (s32 > 64'sd2147483647) || (s32 < -64'sd2147483648);
      m_sum = full[63:0];
      if (xe || xc) begin  // R6
        m_ca = full[64]; m_ca32 = lo[32];
      end
      if (xo) begin  // R7
        m_ov = e_ov; m_ov32 = e_ov32; m_so = m_so | e_ov;
      end
      if (xr) begin
        m_crv = 1'b1;
        m_cr = {full[63], !full[63] && (full[63:0] != 0), full[63:0] == 0, m_so};
      end
    end
    @(negedge clk);
    check_all();
  endtask

  localparam int NV = 16;
  function automatic logic [63:0] edgev(input int k);
    case (k)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'h2;
      3: return 64'h7FFF_FFFE;
      4: return 64'h7FFF_FFFF;
      5: return 64'h8000_0000;
      6: return 64'hFFFF_FFFF;
      7: return 64'h1_0000_0000;
      8: return 64'h7FFF_FFFF_FFFF_FFFF;
      9: return 64'h8000_0000_0000_0000;
      10: return 64'hFFFF_FFFF_FFFF_FFFF;
      11: return 64'hFFFF_FFFF_7FFF_FFFF;
      12: return 64'hFFFF_FFFF_8000_0000;
      13: return 64'h8000_0000_7FFF_FFFF;
      14: return 64'h5555_5555_5555_5555;
      default: return 64'hAAAA_AAAA_AAAA_AAAA;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check_all();  // R11 reset state, all zero
    chk("R11 reset cr_valid", {63'd0, crv}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: low-half overflow only
    op(1, 64'h7FFF_FFFF, 64'h1, 0, 1, 1, 1);
    // R3 / R8: full overflow, sticky set
    op(1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 0, 1, 1, 1);
    // R7: no enable, flags kept
    op(1, 64'h0, 64'h0, 0, 1, 0, 1);
    // R8: enabled, no overflow, sticky stays
    op(1, 64'h1, 64'h1, 0, 1, 1, 1);
    // R6: set carry, then plain add without write keeps it
    op(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 1, 1, 0);
    op(1, 64'h3, 64'h4, 0, 0, 0, 0);
    // R5: extended add, carry-in drives overflow
    op(1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 1, 0, 1, 1);
    // R10: idle
    op(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1, 1);
    // grid sweep around bit 31 and bit 63
    for (int i = 0; i < NV; i++) begin
      for (int j = 0; j < NV; j++) begin
        op(1, edgev(i), edgev(j), i[0], j[0], ((i + j) % 3) != 0, j[1]);
      end
    end
    // random with mixed enables and idle cycles
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] m;
      m = $urandom;
      op(m[0] | m[1], {$urandom, $urandom}, {$urandom, $urandom},
         m[2], m[3], m[4], m[5]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule